// File: doc/BRIEF.md
# Gated Fractional Reference Clock Bank

This block turns one fast source clock into four slower reference rates. Each channel gives a clock-enable stream: a one-cycle pulse on source cycles chosen so that the long-run pulse rate is the source rate times 18 divided by that channel's fraction value. Downstream logic uses the pulses as clock enables, or to gate a clock.

One 32-bit control word holds the setup for all four channels, one byte per channel. Channel i sits in bits 8i+7..8i. The low six bits of the byte are its fraction value. Bit 8i+7 is a stop bit: 1 halts the channel and 0 runs it. Bit 8i+6 is stored and read back but has no effect. Software reaches the word through three write views. The direct view replaces the word. The set view ORs data in. The clear view removes the bits that are 1 in the data. With the set and clear views, one channel can be stopped or started without a read-modify-write that might disturb the others.

Each channel keeps an accumulator. On every source cycle it adds 18. When the sum is at least the fraction value, it subtracts the fraction and emits a pulse. Fraction values outside 18..35 are clamped into that range before use.

Top module: `refclk_bank`

## Requirements
- R1: After reset the control word reads 0x92929292: every channel is stopped with fraction 18. All pulse outputs are low.
- R2: A write with `reg_view`=0 replaces the whole word, and `reg_rdata` shows the new word in the cycle after the write edge. A write with `reg_view`=3 leaves the word unchanged.
- R3: A write with `reg_view`=1 ORs `reg_wdata` into the word.
- R4: A write with `reg_view`=2 clears every word bit whose `reg_wdata` bit is 1 and leaves the other bits as they were.
- R5: While bit 8i+7 is 1, `ref_en[i]` stays low and channel i's accumulator is held at zero. After the bit is cleared, the channel restarts from zero. For example, with fraction 35 the first pulse comes on the second cycle.
- R6: A running channel with fraction F, started from a zero accumulator, gives exactly floor(18·N/F) pulses in N cycles. The pulse in each cycle follows the add-18 / subtract-F accumulator rule, with the pulse registered one cycle after the control word it uses.
- R7: A fraction field below 18 acts as 18, so the channel pulses every cycle. A fraction field above 35 acts as 35.
- R8: A new fraction takes effect at the next accumulator update. The accumulator value carries over, and no pulse is dropped or duplicated.
- R9: A write that changes only byte i affects only channel i's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one per cycle |
| reg_view | input | 2 | Write view: 0 direct, 1 set, 2 clear, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| ref_en | output | 4 | Per-channel clock-enable pulses |

## Verification
The bench builds the block with its default parameters: four channels, byte lanes, step 18 and fraction range 18..35. Because the accumulator stays below 53, all its states are reached within a few hundred cycles. Random writes through all four view codes, with random fraction fields, reach clamped values both below and above the range, as well as mid-run fraction changes and gating of single channels. Directed runs pin down the exact pulse counts for fractions 18, 28 and 35.

// File: rtl/refclk_pkg.sv
`timescale 1ns/1ps
// Shared types for the reference clock bank.
// Assumes the write view is encoded in two bits.
package refclk_pkg;

    // Write view selector decoded by the control register.
    typedef enum logic [1:0] {
        VIEW_DIRECT = 2'd0,
        VIEW_SET    = 2'd1,
        VIEW_CLR    = 2'd2,
        VIEW_NONE   = 2'd3
    } view_e;

endpackage

// File: rtl/refclk_ctrl_regs.sv
`timescale 1ns/1ps
// Control word shared by all channels, written through direct, set and
// clear views. Assumes at most one write per cycle. The word resets to
// RST_LANE repeated in every lane.
module refclk_ctrl_regs
    import refclk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LANE_W = 8,
    parameter logic [LANE_W-1:0] RST_LANE = 8'h92,
    localparam int WORD_W = NUM_CH * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  view_e             view,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] word_nxt;

    // Next word from the selected write view.
    always_comb begin
        word_nxt = word;
        if (wr) begin
            case (view)
                VIEW_DIRECT: word_nxt = wdata;
                VIEW_SET:    word_nxt = word | wdata;
                VIEW_CLR:    word_nxt = word & ~wdata;
                default:     word_nxt = word;
            endcase
        end
    end

    // Hold the word, and reload the stopped default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= {NUM_CH{RST_LANE}};
        else        word <= word_nxt;
    end

endmodule

// File: rtl/refclk_frac_clamp.sv
`timescale 1ns/1ps
// Forces a raw fraction field into the legal range FRAC_MIN..FRAC_MAX.
// Purely combinational. Assumes FRAC_MIN <= FRAC_MAX < 2**FRAC_W.
module refclk_frac_clamp #(
    parameter int FRAC_W   = 6,
    parameter int FRAC_MIN = 18,
    parameter int FRAC_MAX = 35
) (
    input  logic [FRAC_W-1:0] frac_raw,
    output logic [FRAC_W-1:0] frac_use
);

    localparam logic [FRAC_W-1:0] LO = FRAC_W'(FRAC_MIN);
    localparam logic [FRAC_W-1:0] HI = FRAC_W'(FRAC_MAX);

    // Pick the bound if the raw value lies outside it.
    always_comb begin
        if (frac_raw < LO)      frac_use = LO;
        else if (frac_raw > HI) frac_use = HI;
        else                    frac_use = frac_raw;
    end

endmodule

// File: rtl/refclk_accum.sv
`timescale 1ns/1ps
// One channel's pulse generator. Adds STEP every cycle. When the sum
// reaches frac, subtracts frac and registers a one-cycle pulse. Assumes
// frac is already clamped to STEP..FRAC_MAX, so the accumulator stays
// below FRAC_MAX. Stop holds the accumulator at zero.
module refclk_accum #(
    parameter int FRAC_W   = 6,
    parameter int STEP     = 18,
    parameter int FRAC_MAX = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic [FRAC_W-1:0] frac,
    output logic              pulse
);

    localparam int ACC_W = $clog2(FRAC_MAX + STEP + 1);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] frac_ext;
    logic             hit;

    // Candidate sum and the threshold compare.
    always_comb begin
        sum      = SUM_W'(acc) + SUM_W'(STEP);
        frac_ext = SUM_W'(frac);
        hit      = (sum >= frac_ext);
    end

    // Advance the accumulator and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            acc   <= '0;
            pulse <= 1'b0;
        end else if (hit) begin
            acc   <= ACC_W'(sum - frac_ext);
            pulse <= 1'b1;
        end else begin
            acc   <= ACC_W'(sum);
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/refclk_bank.sv
`timescale 1ns/1ps
// Bank of NUM_CH gated fractional reference clock channels. Channel i is
// set up by lane i of the control word: the low FRAC_W bits hold the
// fraction, and the top bit of the lane stops the channel. Pulses are
// registered and use the word as it was before the clock edge.
module refclk_bank
    import refclk_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int LANE_W   = 8,
    parameter int FRAC_W   = 6,
    parameter int STEP     = 18,
    parameter int FRAC_MIN = 18,
    parameter int FRAC_MAX = 35
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [1:0]                 reg_view,
    input  logic [NUM_CH*LANE_W-1:0]   reg_wdata,
    output logic [NUM_CH*LANE_W-1:0]   reg_rdata,
    output logic [NUM_CH-1:0]          ref_en
);

    localparam int WORD_W   = NUM_CH * LANE_W;
    localparam int STOP_POS = LANE_W - 1;
    localparam logic [LANE_W-1:0] RST_LANE =
        LANE_W'((1 << STOP_POS) | FRAC_MIN);

    logic [WORD_W-1:0] word;

    refclk_ctrl_regs #(
        .NUM_CH   (NUM_CH),
        .LANE_W   (LANE_W),
        .RST_LANE (RST_LANE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .view  (view_e'(reg_view)),
        .wdata (reg_wdata),
        .word  (word)
    );

    assign reg_rdata = word;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [FRAC_W-1:0] frac_use;

        refclk_frac_clamp #(
            .FRAC_W   (FRAC_W),
            .FRAC_MIN (FRAC_MIN),
            .FRAC_MAX (FRAC_MAX)
        ) u_clamp (
            .frac_raw (word[i*LANE_W +: FRAC_W]),
            .frac_use (frac_use)
        );

        refclk_accum #(
            .FRAC_W   (FRAC_W),
            .STEP     (STEP),
            .FRAC_MAX (FRAC_MAX)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .stop  (word[i*LANE_W + STOP_POS]),
            .frac  (frac_use),
            .pulse (ref_en[i])
        );
    end

endmodule

// File: rtl/refclk_bank_chk.sv
`timescale 1ns/1ps
// Assertion checker for refclk_bank, attached through bind.
module refclk_bank_chk #(
    parameter int NUM_CH   = 4,
    parameter int LANE_W   = 8,
    parameter int FRAC_W   = 6,
    parameter int FRAC_MIN = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [1:0]               reg_view,
    input logic [NUM_CH*LANE_W-1:0] reg_wdata,
    input logic [NUM_CH*LANE_W-1:0] reg_rdata,
    input logic [NUM_CH-1:0]        ref_en
);

    localparam int WORD_W   = NUM_CH * LANE_W;
    localparam int STOP_POS = LANE_W - 1;
    localparam logic [LANE_W-1:0] RST_LANE =
        LANE_W'((1 << STOP_POS) | FRAC_MIN);

    // R1
    rst_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_rdata == {NUM_CH{RST_LANE}} && ref_en == '0));

    // R2
    direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_view == 2'd0) |=> reg_rdata == $past(reg_wdata));

    // R3
    set_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_view == 2'd1) |=>
            reg_rdata == ($past(reg_rdata) | $past(reg_wdata)));

    // R4
    clr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_view == 2'd2) |=>
            reg_rdata == ($past(reg_rdata) & ~$past(reg_wdata)));

    // R2
    none_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_view == 2'd3) |=> $stable(reg_rdata));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R5
        stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rdata[i*LANE_W + STOP_POS] |=> !ref_en[i]);

        // R7
        min_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_rdata[i*LANE_W + STOP_POS] &&
             reg_rdata[i*LANE_W +: FRAC_W] <= FRAC_W'(FRAC_MIN)) |=> ref_en[i]);
    end

endmodule

bind refclk_bank refclk_bank_chk #(
    .NUM_CH   (NUM_CH),
    .LANE_W   (LANE_W),
    .FRAC_W   (FRAC_W),
    .FRAC_MIN (FRAC_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_view  (reg_view),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ref_en    (ref_en)
);

// File: tb/sim_refclk_bank.sv
`timescale 1ns/1ps
// Bench for refclk_bank: directed corner cases, then random writes, all
// compared every cycle against a behavioural model.
module sim_refclk_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_view = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ref_en;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_word;
    int          m_acc [4];
    logic [3:0]  m_en;
    int          pcount [4];

    refclk_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_view  (reg_view),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ref_en    (ref_en)
    );

    always #4 clk = ~clk;

    function automatic int clampf(int f);
        if (f < 18) return 18;
        if (f > 35) return 35;
        return f;
    endfunction

    function automatic logic [31:0] apply_wr(logic [31:0] w, logic [1:0] v,
                                             logic [31:0] d);
        case (v)
            2'd0:    return d;
            2'd1:    return w | d;
            2'd2:    return w & ~d;
            default: return w;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act,
                         logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model at the edge, compare at the next negedge.
    task automatic step(bit wr, logic [1:0] v, logic [31:0] d);
        reg_wr = wr; reg_view = v; reg_wdata = d;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (m_word[8*i+7]) begin
                m_acc[i] = 0; m_en[i] = 1'b0;
            end else begin
                int f = clampf(int'(m_word[8*i +: 6]));
                int s = m_acc[i] + 18;
                if (s >= f) begin m_acc[i] = s - f; m_en[i] = 1'b1; end
                else        begin m_acc[i] = s;     m_en[i] = 1'b0; end
            end
        end
        if (wr) m_word = apply_wr(m_word, v, d);
        @(negedge clk);
        reg_wr = 1'b0;
        check(reg_rdata == m_word, cur_req, "word", reg_rdata, m_word);
        check(ref_en == m_en, cur_req, "pulses", {28'd0, ref_en}, {28'd0, m_en});
        for (int i = 0; i < 4; i++) if (ref_en[i]) pcount[i]++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 2'd0, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(reg_rdata == 32'h92929292, "R1", "reset word", reg_rdata, 32'h92929292);
        check(ref_en == 4'd0, "R1", "reset pulses", {28'd0, ref_en}, 32'd0);
        m_word = 32'h92929292; m_en = '0;
        for (int i = 0; i < 4; i++) begin m_acc[i] = 0; pcount[i] = 0; end
        cur_req = "R1"; idle(4);

        // R6: exact pulse counts from zero accumulators (ch0 F=35, ch1 F=18, ch2 F=28, ch3 stopped)
        cur_req = "R6";
        step(1'b1, 2'd0, 32'h921C1223);
        for (int i = 0; i < 4; i++) pcount[i] = 0;
        idle(70);
        check(pcount[0] == 36, "R6", "ch0 count F=35", pcount[0], 36);
        check(pcount[1] == 70, "R6", "ch1 count F=18", pcount[1], 70);
        check(pcount[2] == 45, "R6", "ch2 count F=28", pcount[2], 45);
        check(pcount[3] == 0,  "R5", "ch3 stopped count", pcount[3], 0);

        // R5: stop ch0 through the set view, then restart; F=35 gives its first pulse on the second cycle
        cur_req = "R5";
        step(1'b1, 2'd1, 32'h00000080);
        idle(5);
        check(ref_en[0] == 1'b0, "R5", "ch0 stopped", {31'd0, ref_en[0]}, 0);
        step(1'b1, 2'd2, 32'h00000080);
        step(1'b0, 2'd0, 32'd0);
        check(ref_en[0] == 1'b0, "R5", "restart cycle 1", {31'd0, ref_en[0]}, 0);
        step(1'b0, 2'd0, 32'd0);
        check(ref_en[0] == 1'b1, "R5", "restart cycle 2", {31'd0, ref_en[0]}, 1);

        // R7: clamp below and above the range
        cur_req = "R7";
        step(1'b1, 2'd0, 32'h8080_3F00);
        for (int i = 0; i < 4; i++) pcount[i] = 0;
        idle(35);
        check(pcount[0] == 35, "R7", "F=0 acts as 18", pcount[0], 35);
        check(pcount[1] >= 17 && pcount[1] <= 18, "R7", "F=63 acts as 35", pcount[1], 18);

        // R8: change fractions mid-run
        cur_req = "R8";
        idle(7);
        step(1'b1, 2'd0, 32'h8080_1A21);
        idle(11);
        step(1'b1, 2'd0, 32'h8080_2313);
        idle(9);

        // R9: touching one lane leaves the other channels alone
        cur_req = "R9";
        step(1'b1, 2'd0, 32'h1F1E1D1C);
        idle(6);
        step(1'b1, 2'd1, 32'h00800000);
        idle(6);
        step(1'b1, 2'd2, 32'h00000001);
        idle(6);

        // R2: the no-write view code
        cur_req = "R2";
        step(1'b1, 2'd3, 32'hFFFFFFFF);
        idle(3);

        // Random mix over every view and fraction field
        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            bit wr = ($urandom % 3) == 0;
            logic [1:0] v = 2'($urandom % 4);
            logic [31:0] d = $urandom;
            if (($urandom % 4) != 0) d = d & 32'h3F3F3F3F;
            cur_req = (v == 2'd1) ? "R3" : (v == 2'd2) ? "R4" : (v == 2'd0) ? "R8" : "R2";
            step(wr, v, d);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule